// File: doc/BRIEF.md
# Shared Chip-Select Wait-State Adapter

This block sits between a fast host bus and a group of slow 8-bit peripherals that all hang off one host chip select. Two high address bits choose which peripheral the current access is aimed at, and the block turns that choice into one enable per peripheral. It then produces the single active-low transfer-acknowledge (`ta_n`) the host waits on before it ends the bus cycle.

The peripherals report readiness in different ways. The DSP host port raises an active-high ready. The dual-port RAM pulls an active-low busy while its data is not yet valid. The display module gives no indication at all, so a clock counter stands in for it. The counter makes every display access last a fixed, parameterised number of bus clocks: 100 clocks at 100 MHz gives 1 µs. A select code with nothing behind it is acknowledged after a short fixed delay, so a stray access cannot hang the host.

The acknowledge is registered. It is low for exactly one clock per access and stays high until the chip select has been released and asserted again.

Top module: `periph_ack_adapter`

## Requirements
- R1: While `cs_n` is low, `sel` code 2'b00 drives `dsp_en` high, 2'b01 drives `ram_en` high, 2'b10 drives `disp_en` high, and 2'b11 drives none. While `cs_n` is high, all enables are low, and at most one enable is ever high.
- R2: In a DSP access (code 2'b00), `ta_n` is low in the clock that follows the first rising edge at which `dsp_rdy` is sampled high. It stays high while `dsp_rdy` is low.
- R3: In a dual-port RAM access (code 2'b01), `ta_n` stays high while `ram_busy_n` is low. It goes low in the clock that follows the first rising edge at which `ram_busy_n` is sampled high.
- R4: In a display access (code 2'b10), `ta_n` goes low in the clock that follows the DISP_WAIT-th rising edge at which `cs_n` is sampled low. This holds whatever the status inputs do.
- R5: The wait counter returns to zero at every edge where `cs_n` is sampled high. A display access that is cut short therefore leaves no residue, and the next access waits the full DISP_WAIT clocks again.
- R6: `ta_n` is low for exactly one clock per access, even if the chip select stays low afterwards.
- R7: `ta_n` is high in every clock that follows an edge at which `cs_n` was sampled high.
- R8: In an access with the unused code 2'b11, `ta_n` goes low in the clock that follows the SPARE_WAIT-th rising edge with `cs_n` low (default 2).
- R9: After a synchronous active-low reset, `ta_n` is high and no acknowledge comes out until a new access runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Shared host chip select, active low |
| sel | input | 2 | High address bits that pick the peripheral |
| dsp_rdy | input | 1 | DSP host-port ready, active high |
| ram_busy_n | input | 1 | Dual-port RAM busy, active low |
| dsp_en | output | 1 | DSP enable |
| ram_en | output | 1 | Dual-port RAM enable |
| disp_en | output | 1 | Display enable |
| ta_n | output | 1 | Transfer acknowledge to host, active low |

## Verification
The bench builds the block with DISP_WAIT = 12 and SPARE_WAIT = 2. A 12-clock display wait is long enough to cut an access off part-way and check that the counter starts afresh. It is short enough that a mis-counted delay, off by a single edge, still shows up in the exact clock where `ta_n` falls. With the small spare delay, the fallback path and the one-clock minimum of the ready-driven peripherals both land within the first few edges. Off-by-one errors in the counter compare are exposed there too.

// File: rtl/periph_ack_pkg.sv
// Shared definitions for the wait-state adapter.
// Assumes the peripheral select is a 2-bit code taken from high address bits.
package periph_ack_pkg;
    typedef enum logic [1:0] {
        SEL_DSP   = 2'b00,
        SEL_RAM   = 2'b01,
        SEL_DISP  = 2'b10,
        SEL_SPARE = 2'b11
    } periph_sel_e;
endpackage

// File: rtl/periph_sel_decode.sv
// Decodes the shared chip select and select code into per-peripheral enables.
// Assumes cs_n and sel are already synchronous to clk (host bus signals).
module periph_sel_decode
    import periph_ack_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic [1:0] sel,
    output logic       dsp_en,
    output logic       ram_en,
    output logic       disp_en,
    output logic       spare_en
);
    periph_sel_e code;
    assign code = periph_sel_e'(sel);

    // Combinational decode of the select code, gated by the chip select.
    always_comb begin
        dsp_en   = 1'b0;
        ram_en   = 1'b0;
        disp_en  = 1'b0;
        spare_en = 1'b0;
        if (!cs_n) begin
            unique case (code)
                SEL_DSP:   dsp_en   = 1'b1;
                SEL_RAM:   ram_en   = 1'b1;
                SEL_DISP:  disp_en  = 1'b1;
                SEL_SPARE: spare_en = 1'b1;
                default:   spare_en = 1'b1;
            endcase
        end
    end

    // R1
    one_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dsp_en, ram_en, disp_en, spare_en}));
    // R1
    idle_no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !(dsp_en || ram_en || disp_en || spare_en));
endmodule

// File: rtl/access_wait_counter.sv
// Counts bus clocks since the chip select was first sampled low and flags
// when the display and spare delays have elapsed.
// Assumes DISP_WAIT and SPARE_WAIT are at least 1; the count saturates.
module access_wait_counter #(
    parameter int DISP_WAIT  = 100,
    parameter int SPARE_WAIT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    output logic disp_due,
    output logic spare_due
);
    localparam int MAX_WAIT = (DISP_WAIT > SPARE_WAIT) ? DISP_WAIT : SPARE_WAIT;
    localparam int CW       = $clog2(MAX_WAIT + 1);
    localparam logic [CW-1:0] CNT_TOP    = CW'(MAX_WAIT);
    localparam logic [CW-1:0] DISP_LAST  = CW'(DISP_WAIT - 1);
    localparam logic [CW-1:0] SPARE_LAST = CW'(SPARE_WAIT - 1);

    logic [CW-1:0] cnt_q;

    // Clear on idle chip select, otherwise count up to the saturation limit.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n)
            cnt_q <= '0;
        else if (cnt_q != CNT_TOP)
            cnt_q <= cnt_q + 1'b1;
    end

    // Delay-elapsed flags; one edge later the registered acknowledge fires.
    always_comb begin
        disp_due  = (cnt_q >= DISP_LAST);
        spare_due = (cnt_q >= SPARE_LAST);
    end

    // R5
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (cnt_q == '0));
    // R5
    cnt_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_TOP);
endmodule

// File: rtl/ack_merge.sv
// Merges the per-peripheral ready conditions into one registered,
// active-low, single-clock transfer acknowledge.
// Assumes exactly one enable is high while the chip select is low.
module ack_merge (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic dsp_en,
    input  logic ram_en,
    input  logic disp_en,
    input  logic spare_en,
    input  logic dsp_rdy,
    input  logic ram_busy_n,
    input  logic disp_due,
    input  logic spare_due,
    output logic ta_n
);
    logic ready;
    logic fire;
    logic done_q;
    logic ta_n_q;

    // Per-peripheral ready selection, with the polarity of each input normalised.
    always_comb begin
        ready = (dsp_en   &  dsp_rdy)
              | (ram_en   &  ram_busy_n)
              | (disp_en  &  disp_due)
              | (spare_en &  spare_due);
        fire  = !cs_n && !done_q && ready;
    end

    // Acknowledge register plus once-per-access latch, both cleared on idle.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) begin
            ta_n_q <= 1'b1;
            done_q <= 1'b0;
        end else begin
            ta_n_q <= !fire;
            done_q <= done_q | fire;
        end
    end

    assign ta_n = ta_n_q;

    // R6
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ta_n |=> ta_n);
    // R7
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> ta_n);
    // R2
    dsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dsp_en && !dsp_rdy) |=> ta_n);
    // R3
    ram_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_en && !ram_busy_n) |=> ta_n);
endmodule

// File: rtl/periph_ack_adapter.sv
// Top level: shared chip-select decode plus acknowledge generation for a
// DSP host port, a dual-port RAM and a display with no ready line.
// Assumes all inputs are synchronous to clk.
module periph_ack_adapter #(
    parameter int DISP_WAIT  = 100,
    parameter int SPARE_WAIT = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic [1:0] sel,
    input  logic       dsp_rdy,
    input  logic       ram_busy_n,
    output logic       dsp_en,
    output logic       ram_en,
    output logic       disp_en,
    output logic       ta_n
);
    logic spare_en;
    logic disp_due;
    logic spare_due;

    periph_sel_decode u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sel      (sel),
        .dsp_en   (dsp_en),
        .ram_en   (ram_en),
        .disp_en  (disp_en),
        .spare_en (spare_en)
    );

    access_wait_counter #(
        .DISP_WAIT  (DISP_WAIT),
        .SPARE_WAIT (SPARE_WAIT)
    ) u_wait (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .disp_due  (disp_due),
        .spare_due (spare_due)
    );

    ack_merge u_merge (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .dsp_en     (dsp_en),
        .ram_en     (ram_en),
        .disp_en    (disp_en),
        .spare_en   (spare_en),
        .dsp_rdy    (dsp_rdy),
        .ram_busy_n (ram_busy_n),
        .disp_due   (disp_due),
        .spare_due  (spare_due),
        .ta_n       (ta_n)
    );

    // R9
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> ta_n);
endmodule

// File: tb/periph_ack_adapter_tb_top.sv
module periph_ack_adapter_tb_top;
    localparam int DW = 12;
    localparam int SW = 2;
    localparam int NV = 9;
    // Vector table: select code, clocks the ready/busy is held off, expected edges to ack.
    localparam int V_CODE[NV]  = '{0, 0, 0, 1, 1, 1, 2, 3, 2};
    localparam int V_DELAY[NV] = '{0, 3, 1, 0, 5, 2, 4, 0, 0};
    localparam int V_EXP[NV]   = '{1, 4, 2, 1, 6, 3, DW, SW, DW};

    logic clk = 0;
    logic rst_n = 0;
    logic cs_n = 1;
    logic [1:0] sel = 0;
    logic dsp_rdy = 0;
    logic ram_busy_n = 0;
    logic dsp_en, ram_en, disp_en, ta_n;
    int checks = 0;
    int fails = 0;
    bit timed_out = 0;

    always #5 clk = ~clk;

    periph_ack_adapter #(.DISP_WAIT(DW), .SPARE_WAIT(SW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sel(sel),
        .dsp_rdy(dsp_rdy), .ram_busy_n(ram_busy_n),
        .dsp_en(dsp_en), .ram_en(ram_en), .disp_en(disp_en), .ta_n(ta_n));

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic edge_wait();
        @(posedge clk);
        #1;
    endtask

    // Runs one access; returns the edge number at which ta_n was first seen low (0 if none).
    task automatic run_access(input int code, input int delay, input int limit, output int got);
        got = 0;
        sel = 2'(code);
        dsp_rdy = (delay == 0);
        ram_busy_n = (delay == 0);
        cs_n = 0;
        #1;
        check("R1", {dsp_en, ram_en, disp_en},
              code == 0 ? 3'b100 : code == 1 ? 3'b010 : code == 2 ? 3'b001 : 3'b000);
        for (int n = 1; n <= limit; n++) begin
            edge_wait();
            if (!ta_n && got == 0) got = n;
            if (n == delay) begin
                dsp_rdy = 1;
                ram_busy_n = 1;
            end
        end
    endtask

    task automatic release_cs();
        cs_n = 1;
        dsp_rdy = 0;
        ram_busy_n = 0;
        edge_wait();
        check("R7", ta_n, 1);
        check("R1", {dsp_en, ram_en, disp_en}, 0);
    endtask

    initial begin
        #2000000;
        timed_out = 1;
    end

    initial begin
        int got;
        repeat (3) edge_wait();
        check("R9", ta_n, 1);
        rst_n = 1;
        edge_wait();
        check("R9", ta_n, 1);

        for (int i = 0; i < NV; i++) begin
            run_access(V_CODE[i], V_DELAY[i], V_EXP[i], got);
            check(V_CODE[i] == 0 ? "R2" : V_CODE[i] == 1 ? "R3" : V_CODE[i] == 2 ? "R4" : "R8",
                  got, V_EXP[i]);
            edge_wait();
            check("R6", ta_n, 1);
            edge_wait();
            check("R6", ta_n, 1);
            release_cs();
        end

        // R5: display access cut short, then a fresh access waits the full count
        run_access(2, 0, 5, got);
        check("R5", got, 0);
        release_cs();
        run_access(2, 0, DW + 2, got);
        check("R5", got, DW);
        release_cs();

        // R3: RAM busy held for a long time, no acknowledge
        run_access(1, 50, 20, got);
        check("R3", got, 0);
        release_cs();

        // R2: DSP ready never raised, no acknowledge
        run_access(0, 50, 20, got);
        check("R2", got, 0);
        release_cs();

        // R7: idle bus with ready lines high, no acknowledge
        dsp_rdy = 1;
        ram_busy_n = 1;
        got = 0;
        for (int n = 0; n < 10; n++) begin
            edge_wait();
            if (!ta_n) got = 1;
        end
        check("R7", got, 0);

        // R9: reset in the middle of an access clears the acknowledge path
        run_access(2, 0, DW - 1, got);
        rst_n = 0;
        edge_wait();
        check("R9", ta_n, 1);
        rst_n = 1;
        got = 0;
        for (int n = 0; n < 3; n++) begin
            edge_wait();
            if (!ta_n) got = 1;
        end
        check("R9", got, 0);
        release_cs();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    always @(posedge timed_out) begin
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule